// File: doc/BRIEF.md
# Sampled Angle and Rate Host Port

This block sits between an angle/velocity tracking core and a host processor. The core presents its live position integrator, live velocity integrator and fault flags on plain input buses. A falling edge on a sample strobe freezes all three into holding registers in the same clock, so a host read never mixes values from two different moments. The host reads those held values through one of two ports: a 16-bit parallel bus or a 4-wire serial port. A strap input picks the port.

Two mode inputs choose what a read returns: held position, held velocity, or a byte of a small configuration register file. In configuration mode the host writes bytes. A byte with its top bit set selects a register. A byte with its top bit clear is data for the selected register. Writes that come too soon after the previous accepted write are dropped. The register contents go out as a flat bus to the tracking core. The strobe, serial clock, frame and data inputs are asynchronous to the core clock and are synchronised inside the block.

Top module: `angle_host_if`

## Requirements
- R1: A high-to-low transition on `sample_i` copies `pos_live_i`, `vel_live_i` and `flt_live_i` into the held position, velocity and fault registers in the same clock.
- R2: With no falling edge on `sample_i`, the held registers do not change. This holds when the live inputs move and when `sample_i` only rises.
- R3: The resolution code `res_i` is applied at capture. Codes 0, 1, 2 and 3 keep the top 10, 12, 14 and 16 bits of position and velocity, and force the lower bits to zero. The word stays left-aligned in 16 bits.
- R4: `db_oe_o` is high only while `par_sel_i` is 1, `cs_ni` is 0 and `rd_ni` is 0. Otherwise `db_o` is zero. The read word depends on `mode_i` (bit 1, bit 0):
  - 00 gives held position.
  - 10 gives held velocity.
  - 11 gives the selected configuration byte, zero-extended.
  - 01 gives zero.
- R5: With `par_sel_i` at 0, a fall of `wr_ni` while `cs_ni` is low loads a 24-bit frame: the 16-bit read word of R4 followed by the 8 held fault bits. The frame leaves on `sdo_o` MSB first. The first bit is present right after the frame starts, and each rising `sclk_i` edge advances one bit.
- R6: In a serial frame, `sdi_i` is sampled on each falling `sclk_i` edge, MSB first. If exactly 8 bits have been sampled when `wr_ni` rises, those 8 bits become a configuration write.
- R7: A configuration write byte with bit 7 set selects register `byte[1:0]`. With bit 7 clear, `byte[6:0]` is stored in the selected register and bit 7 of that register reads 0. A parallel write takes `db_i` when `wr_ni` rises with `cs_ni` low and `par_sel_i` at 1.
- R8: Writes made while `mode_i` is not 11 leave every register and the selection unchanged.
- R9: A write is dropped if it comes fewer than 6 clocks after an accepted data write. After an accepted select write, the spacing needed is 2 clocks. Spacing is counted between rising `wr_ni` edges.
- R10: After reset, all held registers, configuration registers and the selection are zero, `db_oe_o` is 0 and `sdo_o` is 0.
- R11: `cfg_o` carries register n in bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| par_sel_i | input | 1 | strap: 1 parallel port, 0 serial port |
| cs_ni | input | 1 | chip select, active low |
| rd_ni | input | 1 | parallel read enable, active low; held high in serial mode |
| wr_ni | input | 1 | parallel write strobe / serial frame, active low |
| sample_i | input | 1 | snapshot strobe, captures on falling edge |
| mode_i | input | 2 | read/write mode select |
| res_i | input | 2 | resolution code |
| sclk_i | input | 1 | serial clock |
| sdi_i | input | 1 | serial data in |
| sdo_o | output | 1 | serial data out |
| db_i | input | 8 | parallel write data |
| db_o | output | 16 | parallel read data |
| db_oe_o | output | 1 | parallel read drive enable |
| pos_live_i | input | 16 | live position from tracking core |
| vel_live_i | input | 16 | live velocity from tracking core |
| flt_live_i | input | 8 | live fault flags |
| cfg_o | output | 32 | configuration registers to the core |

## Verification
The bench moves the live buses between strobes and raises `sample_i` without lowering it. A design that captured on the rising edge, or captured continuously, would return the newer value.

It reads a full serial frame and compares the trailing fault byte. This catches a frame that is too short or a shift that runs in the wrong direction.

It times writes on both sides of the spacing limits. A wrong counter would either overwrite a register or lose a legal write after a select.

It writes in normal mode and reads with an all-ones live word at reduced resolution. These expose write decode that ignores the mode and a mask that is off by one bit.

// File: rtl/angle_host_pkg.sv
package angle_host_pkg;
  typedef enum logic [1:0] {
    MODE_POS = 2'b00,
    MODE_RSV = 2'b01,
    MODE_VEL = 2'b10,
    MODE_CFG = 2'b11
  } mode_e;

  localparam int MIN_RES_BITS = 10;
endpackage

// File: rtl/ahi_sync_edge.sv
module ahi_sync_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/ahi_snapshot.sv
module ahi_snapshot
  import angle_host_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [1:0]    res_i,
  input  logic [DW-1:0] pos_i,
  input  logic [DW-1:0] vel_i,
  input  logic [FW-1:0] flt_i,
  output logic [DW-1:0] pos_o,
  output logic [DW-1:0] vel_o,
  output logic [FW-1:0] flt_o
);
  logic [DW-1:0] mask;
  logic [DW-1:0] pos_q, vel_q;
  logic [FW-1:0] flt_q;
  int sh;

  always_comb begin
    sh   = DW - MIN_RES_BITS - 2 * int'(res_i);
    mask = {DW{1'b1}} << sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      vel_q <= '0;
      flt_q <= '0;
    end else if (cap_i) begin
      pos_q <= pos_i & mask;
      vel_q <= vel_i & mask;
      flt_q <= flt_i;
    end
  end

  assign pos_o = pos_q;
  assign vel_o = vel_q;
  assign flt_o = flt_q;

  p_snap_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(pos_q) && $stable(vel_q) && $stable(flt_q)));

  p_lsb_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (((pos_q | vel_q) & ~$past(mask)) == '0));
endmodule

// File: rtl/ahi_cfg_regs.sv
module ahi_cfg_regs #(
  parameter int NREG      = 4,
  parameter int BW        = 8,
  parameter int ADDR_GAP  = 2,
  parameter int WRITE_GAP = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               cfg_mode_i,
  input  logic [BW-1:0]      byte_i,
  output logic [BW-1:0]      rd_o,
  output logic [NREG*BW-1:0] regs_o
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int GW = $clog2(WRITE_GAP + 1);

  logic [NREG-1:0][BW-1:0] regs_q;
  logic [AW-1:0]           sel_q;
  logic [GW-1:0]           gap_q;
  logic                    last_addr_q;
  logic                    spacing_ok, accept;

  assign spacing_ok = last_addr_q ? (gap_q >= GW'(ADDR_GAP)) : (gap_q >= GW'(WRITE_GAP));
  assign accept     = we_i & cfg_mode_i & spacing_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q      <= '0;
      sel_q       <= '0;
      gap_q       <= GW'(WRITE_GAP);
      last_addr_q <= 1'b0;
    end else begin
      if (accept) gap_q <= GW'(1);
      else if (gap_q < GW'(WRITE_GAP)) gap_q <= gap_q + GW'(1);
      if (accept) begin
        if (byte_i[BW-1]) begin
          sel_q       <= byte_i[AW-1:0];
          last_addr_q <= 1'b1;
        end else begin
          regs_q[sel_q] <= {1'b0, byte_i[BW-2:0]};
          last_addr_q   <= 1'b0;
        end
      end
    end
  end

  assign rd_o   = regs_q[sel_q];
  assign regs_o = regs_q;

  p_mode_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || !cfg_mode_i) |=> ($stable(regs_q) && $stable(sel_q)));

  p_write_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !last_addr_q && gap_q < GW'(WRITE_GAP)) |=> ($stable(regs_q) && $stable(sel_q)));
endmodule

// File: rtl/ahi_serial.sv
module ahi_serial #(
  parameter int DW = 16,
  parameter int FW = 8,
  parameter int BW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_fall_i,
  input  logic            frame_rise_i,
  input  logic            sclk_rise_i,
  input  logic            sclk_fall_i,
  input  logic            sdi_i,
  input  logic [DW+FW-1:0] load_i,
  output logic            sdo_o,
  output logic [BW-1:0]   byte_o,
  output logic            byte_vld_o
);
  localparam int TW = DW + FW;
  localparam int CW = $clog2(BW + 1);

  logic [TW-1:0] tx_q;
  logic [BW-1:0] rx_q;
  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      rx_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (frame_fall_i) begin
      tx_q     <= load_i;
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (frame_rise_i) active_q <= 1'b0;
      if (sclk_rise_i) tx_q <= {tx_q[TW-2:0], 1'b0};
      if (sclk_fall_i) begin
        rx_q <= {rx_q[BW-2:0], sdi_i};
        if (cnt_q <= CW'(BW)) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign sdo_o      = tx_q[TW-1];
  assign byte_o     = rx_q;
  assign byte_vld_o = frame_rise_i & active_q & (cnt_q == CW'(BW));

  p_tx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_fall_i && !(active_q && sclk_rise_i)) |=> $stable(tx_q));
endmodule

// File: rtl/angle_host_if.sv
module angle_host_if
  import angle_host_pkg::*;
#(
  parameter int DW        = 16,
  parameter int FW        = 8,
  parameter int BW        = 8,
  parameter int NREG      = 4,
  parameter int ADDR_GAP  = 2,
  parameter int WRITE_GAP = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               par_sel_i,
  input  logic               cs_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic               sample_i,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         res_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  input  logic [BW-1:0]      db_i,
  output logic [DW-1:0]      db_o,
  output logic               db_oe_o,
  input  logic [DW-1:0]      pos_live_i,
  input  logic [DW-1:0]      vel_live_i,
  input  logic [FW-1:0]      flt_live_i,
  output logic [NREG*BW-1:0] cfg_o
);
  localparam int B_CS = 0, B_WR = 1, B_SCLK = 2, B_SMP = 3, B_SDI = 4;
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] sync_lvl, sync_rise, sync_fall;
  logic [DW-1:0]    pos_h, vel_h, rd_word;
  logic [FW-1:0]    flt_h;
  logic [BW-1:0]    cfg_rd, ser_byte, wr_byte;
  logic             ser_en, ser_sdo, ser_vld, par_we, cfg_we;
  logic             frame_fall, frame_rise;
  logic             unused_edges;

  ahi_sync_edge #(.W(NSYNC), .RST_VAL(5'b00011)) i_sync (
    .clk_i, .rst_ni,
    .d_i   ({sdi_i, sample_i, sclk_i, wr_ni, cs_ni}),
    .lvl_o (sync_lvl),
    .rise_o(sync_rise),
    .fall_o(sync_fall)
  );
  assign unused_edges = ^{sync_rise[B_CS], sync_fall[B_CS], sync_rise[B_SDI],
                          sync_fall[B_SDI], sync_rise[B_SMP], sync_lvl[B_WR],
                          sync_lvl[B_SCLK], sync_lvl[B_SMP]};

  ahi_snapshot #(.DW(DW), .FW(FW)) i_snap (
    .clk_i, .rst_ni,
    .cap_i(sync_fall[B_SMP]),
    .res_i,
    .pos_i(pos_live_i), .vel_i(vel_live_i), .flt_i(flt_live_i),
    .pos_o(pos_h), .vel_o(vel_h), .flt_o(flt_h)
  );

  always_comb begin
    unique case (mode_e'(mode_i))
      MODE_POS: rd_word = pos_h;
      MODE_VEL: rd_word = vel_h;
      MODE_CFG: rd_word = DW'(cfg_rd);
      default:  rd_word = '0;
    endcase
  end

  assign ser_en     = ~par_sel_i;
  assign frame_fall = ser_en & sync_fall[B_WR] & ~sync_lvl[B_CS];
  assign frame_rise = ser_en & sync_rise[B_WR];

  ahi_serial #(.DW(DW), .FW(FW), .BW(BW)) i_ser (
    .clk_i, .rst_ni,
    .frame_fall_i(frame_fall),
    .frame_rise_i(frame_rise),
    .sclk_rise_i (sync_rise[B_SCLK]),
    .sclk_fall_i (sync_fall[B_SCLK]),
    .sdi_i       (sync_lvl[B_SDI]),
    .load_i      ({rd_word, flt_h}),
    .sdo_o       (ser_sdo),
    .byte_o      (ser_byte),
    .byte_vld_o  (ser_vld)
  );

  assign par_we  = par_sel_i & sync_rise[B_WR] & ~sync_lvl[B_CS];
  assign cfg_we  = par_we | ser_vld;
  assign wr_byte = par_sel_i ? db_i : ser_byte;

  ahi_cfg_regs #(.NREG(NREG), .BW(BW), .ADDR_GAP(ADDR_GAP), .WRITE_GAP(WRITE_GAP)) i_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we),
    .cfg_mode_i(mode_i == MODE_CFG),
    .byte_i    (wr_byte),
    .rd_o      (cfg_rd),
    .regs_o    (cfg_o)
  );

  assign db_oe_o = par_sel_i & ~cs_ni & ~rd_ni;
  assign db_o    = db_oe_o ? rd_word : '0;
  assign sdo_o   = ser_en & ser_sdo;

  p_read_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_oe_o && $past(db_oe_o) && $stable(mode_i) && !$past(sync_fall[B_SMP]) && !$past(cfg_we))
      |-> $stable(db_o));
endmodule

// File: tb/test_angle_host_if.sv
module test_angle_host_if;
  logic        clk = 0, rst_ni = 0;
  logic        par_sel_i = 1, cs_ni = 1, rd_ni = 1, wr_ni = 1, sample_i = 0;
  logic [1:0]  mode_i = 0, res_i = 2'b11;
  logic        sclk_i = 0, sdi_i = 0, sdo_o;
  logic [7:0]  db_i = 0;
  logic [15:0] db_o;
  logic        db_oe_o;
  logic [15:0] pos_live_i = 0, vel_live_i = 0;
  logic [7:0]  flt_live_i = 0;
  logic [31:0] cfg_o;

  int compared = 0, mismatched = 0, cyc = 0;
  logic [15:0] e_pos = 0, e_vel = 0;
  logic [7:0]  e_flt = 0;
  logic [7:0]  e_regs[4] = '{default: 8'h00};
  int          e_sel = 0, last_acc = -1000;
  bit          last_addr = 0;

  angle_host_if i_angle_host_if (.*, .clk_i(clk));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R10: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(logic [1:0] r);
    return 16'hFFFF << (16 - (10 + 2 * int'(r)));
  endfunction

  function automatic logic [31:0] regs_flat();
    return {e_regs[3], e_regs[2], e_regs[1], e_regs[0]};
  endfunction

  // behavioural model of one write attempt
  task automatic model_write(logic [7:0] b, logic [1:0] m, int t);
    int need = last_addr ? 2 : 6;
    if (m == 2'b11 && (t - last_acc) >= need) begin
      last_acc = t;
      if (b[7]) begin e_sel = int'(b[1:0]); last_addr = 1; end
      else begin e_regs[e_sel] = {1'b0, b[6:0]}; last_addr = 0; end
    end
  endtask

  task automatic do_sample();
    sample_i = 1; tick(4);
    sample_i = 0; tick(5);
    e_pos = pos_live_i & msk(res_i);
    e_vel = vel_live_i & msk(res_i);
    e_flt = flt_live_i;
  endtask

  task automatic par_read(logic [1:0] m, output logic [15:0] d, output logic oe);
    mode_i = m; cs_ni = 0; rd_ni = 0;
    #2 d = db_o; oe = db_oe_o;
    tick(1); rd_ni = 1; cs_ni = 1;
  endtask

  task automatic par_write(logic [7:0] b, logic [1:0] m, int post);
    @(negedge clk); mode_i = m; cs_ni = 0; db_i = b; wr_ni = 0;
    @(negedge clk); wr_ni = 1;
    model_write(b, m, cyc);
    tick(post);
    if (post >= 4) cs_ni = 1;
  endtask

  task automatic ser_read(logic [1:0] m, output logic [23:0] fr);
    mode_i = m; cs_ni = 0; tick(1);
    wr_ni = 0; tick(5);
    fr[23] = sdo_o;
    for (int i = 22; i >= 0; i--) begin
      sclk_i = 1; tick(5);
      sclk_i = 0; tick(5);
      fr[i] = sdo_o;
    end
    wr_ni = 1; tick(5); cs_ni = 1; tick(2);
  endtask

  task automatic ser_write(logic [7:0] b);
    mode_i = 2'b11; cs_ni = 0; tick(1);
    wr_ni = 0; tick(5);
    for (int i = 7; i >= 0; i--) begin
      sdi_i = b[i];
      sclk_i = 1; tick(5);
      sclk_i = 0; tick(5);
    end
    wr_ni = 1;
    model_write(b, 2'b11, cyc);
    tick(8); cs_ni = 1; tick(2);
  endtask

  initial begin
    logic [15:0] d;
    logic        oe;
    logic [23:0] fr;
    tick(3); rst_ni = 1; tick(2);

    // R10 reset state
    chk("R10 oe", {31'b0, db_oe_o}, 0);
    chk("R10 sdo", {31'b0, sdo_o}, 0);
    chk("R10 cfg", cfg_o, 0);
    par_read(2'b00, d, oe);
    chk("R10 held pos", {16'b0, d}, 0);

    // R1 capture, full resolution
    pos_live_i = 16'hA5C3; vel_live_i = 16'h1234; flt_live_i = 8'h5A;
    do_sample();
    par_read(2'b00, d, oe); chk("R1 pos", {16'b0, d}, {16'b0, e_pos});
    par_read(2'b10, d, oe); chk("R1 vel", {16'b0, d}, {16'b0, e_vel});
    chk("R4 oe asserted", {31'b0, oe}, 1);

    // R2 live moves, strobe only rises
    pos_live_i = 16'h0F0F; vel_live_i = 16'hBEEF; flt_live_i = 8'h81;
    sample_i = 1; tick(6);
    par_read(2'b00, d, oe); chk("R2 pos held", {16'b0, d}, {16'b0, e_pos});
    par_read(2'b10, d, oe); chk("R2 vel held", {16'b0, d}, {16'b0, e_vel});
    sample_i = 0; tick(5);
    e_pos = pos_live_i; e_vel = vel_live_i; e_flt = flt_live_i;
    par_read(2'b00, d, oe); chk("R1 pos after fall", {16'b0, d}, {16'b0, e_pos});

    // R3 resolution masks
    pos_live_i = 16'hFFFF; vel_live_i = 16'hFFFF; res_i = 2'b01;
    do_sample();
    par_read(2'b00, d, oe); chk("R3 12-bit pos", {16'b0, d}, 32'h0000FFF0);
    res_i = 2'b00; do_sample();
    par_read(2'b10, d, oe); chk("R3 10-bit vel", {16'b0, d}, 32'h0000FFC0);
    res_i = 2'b10; do_sample();
    par_read(2'b00, d, oe); chk("R3 14-bit pos", {16'b0, d}, 32'h0000FFFC);
    res_i = 2'b11;
    pos_live_i = 16'hC35A; vel_live_i = 16'h7E01; flt_live_i = 8'hA7;
    do_sample();

    // R4 gating and reserved mode
    mode_i = 2'b00; cs_ni = 0; rd_ni = 1; #2;
    chk("R4 rd high oe", {31'b0, db_oe_o}, 0);
    chk("R4 rd high bus", {16'b0, db_o}, 0);
    tick(1); cs_ni = 1;
    par_read(2'b01, d, oe); chk("R4 reserved mode", {16'b0, d}, 0);

    // R7/R11 parallel config writes and readback
    par_write(8'h81, 2'b11, 8);
    par_write(8'h2A, 2'b11, 8);
    chk("R11 cfg bus", cfg_o, regs_flat());
    chk("R7 reg1 value", {24'b0, cfg_o[15:8]}, 32'h2A);
    par_read(2'b11, d, oe); chk("R7 cfg read", {16'b0, d}, 32'h2A);

    // R8 writes in normal mode ignored
    par_write(8'h83, 2'b00, 8);
    par_write(8'h11, 2'b10, 8);
    chk("R8 cfg unchanged", cfg_o, regs_flat());
    par_read(2'b11, d, oe); chk("R8 selection kept", {16'b0, d}, 32'h2A);

    // R9 spacing: data then data 4 clocks later dropped
    par_write(8'h15, 2'b11, 2);
    par_write(8'h33, 2'b11, 8);
    chk("R9 early write dropped", cfg_o, regs_flat());
    chk("R9 reg1 value", {24'b0, cfg_o[15:8]}, 32'h15);
    // select then data 4 clocks later accepted
    par_write(8'h83, 2'b11, 2);
    par_write(8'h66, 2'b11, 8);
    chk("R9 data after select", {24'b0, cfg_o[31:24]}, 32'h66);
    // data then select at exactly 6 accepted
    par_write(8'h44, 2'b11, 4);
    par_write(8'h80, 2'b11, 8);
    par_write(8'h09, 2'b11, 8);
    chk("R9 six clock spacing", cfg_o, regs_flat());

    // serial port
    par_sel_i = 0; tick(2);
    mode_i = 2'b00; cs_ni = 0; rd_ni = 0; #2;
    chk("R4 serial strap oe", {31'b0, db_oe_o}, 0);
    tick(1); rd_ni = 1; cs_ni = 1; tick(2);

    ser_read(2'b00, fr); chk("R5 pos frame", {8'b0, fr}, {8'b0, e_pos, e_flt});
    ser_read(2'b10, fr); chk("R5 vel frame", {8'b0, fr}, {8'b0, e_vel, e_flt});

    ser_write(8'h82);
    ser_write(8'h4C);
    chk("R6 serial write", cfg_o, regs_flat());
    chk("R6 reg2 value", {24'b0, cfg_o[23:16]}, 32'h4C);
    ser_read(2'b11, fr); chk("R5 cfg frame", {8'b0, fr}, {8'b0, 8'h00, 8'h4C, e_flt});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule